// File: doc/BRIEF.md
# Programmable Slave Window Decoder

This block checks each incoming bus address against two programmable slave windows. One window lives in a 24-bit address space and one in a 32-bit address space. When an access falls inside a window that may answer it, the block reports a hit, says which window matched, and gives the byte offset into the window. It also raises a location-monitor flag when the access lands in the final 32-bit word of the window. A small register interface sets each window's base and size, a global bus enable, and a way to clear a sticky configuration-error flag.

Each window is controlled by a three-state machine. The states are `WS_UNPROG`, `WS_PARKED` and `WS_LIVE`. The transitions are:

- **program**: `WS_UNPROG` goes to `WS_PARKED` or to `WS_LIVE` on the first accepted base/size write; which one depends on the enable value taking effect at that edge.
- **arm**: `WS_PARKED` goes to `WS_LIVE` when the enable becomes 1.
- **disarm**: `WS_LIVE` goes to `WS_PARKED` when the enable becomes 0.
- **reset**: any state goes back to `WS_UNPROG` on an asynchronous reset.

Accesses made by the local processor are flagged with `acc_local`. They are decoded in `WS_PARKED` and in `WS_LIVE`, but they never raise `dec_bus`. That signal marks a hit that the system-bus path must serve.

Configuration writes use `cfg_sel`, as shown below. A write to code 3 has no effect.

| `cfg_sel` | Target | Meaning of the write |
|---|---|---|
| 0 | 24-bit window | `cfg_base` is the base, `cfg_code` is the size code |
| 1 | 32-bit window | `cfg_base` is the base, `cfg_code` is the size code |
| 2 | control | `cfg_base[0]` is the new enable; `cfg_base[1]` = 1 clears the error flag |
| 3 | none | no effect |

Top module: `swd_decoder`

## Requirements
- R1: After reset, neither window reports a hit for any access. `stat_ready` is 2'b00, and `stat_enable` and `stat_cfg_err` are 0.
- R2: A non-local access hits only when its window is programmed and `stat_enable` is 1. A write with `cfg_sel`=2 sets `stat_enable` to `cfg_base[0]`. A hit on a non-local access raises `dec_bus`.
- R3: The size of the 24-bit window (`cfg_sel`=0) is 512 KB << `cfg_code` for codes 0 to 3. Any code above 3 is rejected.
- R4: The base of the 24-bit window must have bits 31:24 at zero and must be a multiple of the window size. Since the smallest size is 512 KB, this alignment is never finer than 512 KB. Any other base is rejected.
- R5: The size of the 32-bit window (`cfg_sel`=1) is 4 KB << `cfg_code` for codes 0 to 15. Its base must have bits 26:0 at zero, and any other base is rejected.
- R6: An access hits when the address bits at or above the size exponent equal the base. In that case `dec_offset` is the address bits below the size, and every other bit of `dec_offset` is 0. For the 24-bit window (`acc_wide`=0), address bits 31:24 are ignored.
- R7: `dec_lmon` is 1 exactly when a hit has an offset in the range size-4 to size-1.
- R8: A hit on an access with `acc_local`=1 is decoded whenever the window is programmed, whatever the enable. `dec_bus` stays 0 for such an access.
- R9: A rejected write leaves the window's state, base and size unchanged and sets `stat_cfg_err`. The flag stays set until a control write with `cfg_base[1]`=1.
- R10: The first accepted write to a window sets that window's bit in `stat_ready` (bit 0 for the 24-bit window, bit 1 for the 32-bit window). The bit stays set until reset.
- R11: The decode outputs appear one clock after the access is presented. A configuration write affects accesses from the next clock onward, so an access presented in the same cycle as the write uses the old settings.
- R12: `dec_wide` is 1 for a hit in the 32-bit window and 0 otherwise. An access with `acc_wide`=0 is matched only against the 24-bit window, and `acc_wide`=1 only against the 32-bit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| cfg_we | input | 1 | configuration write strobe |
| cfg_sel | input | 2 | write target: 0 = 24-bit window, 1 = 32-bit window, 2 = control |
| cfg_base | input | 32 | base address; for control writes, bit 0 is the enable and bit 1 clears the error flag |
| cfg_code | input | 4 | size code |
| acc_valid | input | 1 | an access is presented this cycle |
| acc_wide | input | 1 | 1 = 32-bit space, 0 = 24-bit space |
| acc_local | input | 1 | the access comes from the local processor |
| acc_addr | input | 32 | access address |
| dec_hit | output | 1 | the access fell inside a window that may answer it |
| dec_wide | output | 1 | the hit is in the 32-bit window |
| dec_offset | output | 32 | byte offset into the window |
| dec_lmon | output | 1 | the hit is in the final 32-bit word of the window |
| dec_bus | output | 1 | the hit must be served on the system bus |
| stat_ready | output | 2 | per-window programmed flag |
| stat_enable | output | 1 | global bus enable |
| stat_cfg_err | output | 1 | sticky flag for a rejected configuration write |

## Verification
The bench probes each window one byte inside and one byte outside its edges, using the smallest and the largest size of each window. A wrong mask would either let an access through at the boundary or cut off the final word.

It tries bases that are aligned to 512 KB but not to a larger 24-bit window. It also tries 32-bit bases that are aligned only to 4 KB, and 24-bit bases with bit 24 set. A weak alignment check would accept these writes and move the window.

Local accesses are made while the enable is off, to catch a design that ties local decode to the enable or lets it reach the bus. An access presented in the same cycle as a reprogramming write shows whether the old window is used for that access.

// File: rtl/swd_pkg.sv
package swd_pkg;
    typedef enum logic [1:0] {
        WS_UNPROG = 2'd0,
        WS_PARKED = 2'd1,
        WS_LIVE   = 2'd2
    } win_state_e;

    localparam int unsigned SWD_AW     = 32;
    localparam int unsigned SWD_CODE_W = 4;

    localparam logic [1:0] CFG_SEL_NARROW = 2'd0;
    localparam logic [1:0] CFG_SEL_WIDE   = 2'd1;
    localparam logic [1:0] CFG_SEL_CTRL   = 2'd2;
endpackage

// File: rtl/swd_cfg_check.sv
module swd_cfg_check #(
    parameter int unsigned AW          = 32,
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned MIN_EXP     = 19,
    parameter int unsigned MAX_CODE    = 3,
    parameter int unsigned ALIGN_FLOOR = 19,
    parameter int unsigned SPACE_BITS  = 24
) (
    input  logic [AW-1:0]     base_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              ok_o,
    output logic [AW-1:0]     mask_o
);
    localparam logic [AW-1:0] SPACE_KEEP = AW'((64'd1 << SPACE_BITS) - 64'd1);

    logic [6:0]    exp_w;
    logic [6:0]    align_w;
    logic [AW-1:0] align_mask;
    logic          code_ok;

    always_comb begin
        exp_w      = 7'(MIN_EXP) + 7'(code_i);
        align_w    = (exp_w > 7'(ALIGN_FLOOR)) ? exp_w : 7'(ALIGN_FLOOR);
        mask_o     = AW'((64'd1 << exp_w) - 64'd1);
        align_mask = AW'((64'd1 << align_w) - 64'd1);
        code_ok    = (32'(code_i) <= MAX_CODE);
        ok_o       = code_ok
                  && ((base_i & align_mask) == '0)
                  && ((base_i & ~SPACE_KEEP) == '0);
    end
endmodule

// File: rtl/swd_window.sv
module swd_window
    import swd_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned CODE_W      = 4,
    parameter int unsigned MIN_EXP     = 19,
    parameter int unsigned MAX_CODE    = 3,
    parameter int unsigned ALIGN_FLOOR = 19,
    parameter int unsigned SPACE_BITS  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_base,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              en_next,
    input  logic              acc_valid,
    input  logic              acc_sel,
    input  logic              acc_local,
    input  logic [AW-1:0]     acc_addr,
    output logic              hit_o,
    output logic              lmon_o,
    output logic              bus_o,
    output logic              ready_o,
    output logic              reject_o,
    output logic [AW-1:0]     off_o
);
    localparam logic [AW-1:0] SPACE_KEEP = AW'((64'd1 << SPACE_BITS) - 64'd1);

    win_state_e    state_q, state_d;
    logic [AW-1:0] base_q, mask_q;
    logic          cfg_ok;
    logic [AW-1:0] cfg_mask;
    logic          cfg_take;

    logic [AW-1:0] addr_in, off_d;
    logic          programmed, hit_d, lmon_d, bus_d;

    swd_cfg_check #(
        .AW(AW), .CODE_W(CODE_W), .MIN_EXP(MIN_EXP), .MAX_CODE(MAX_CODE),
        .ALIGN_FLOOR(ALIGN_FLOOR), .SPACE_BITS(SPACE_BITS)
    ) u_check (
        .base_i (wr_base),
        .code_i (wr_code),
        .ok_o   (cfg_ok),
        .mask_o (cfg_mask)
    );

    assign cfg_take = wr_en && cfg_ok;
    assign reject_o = wr_en && !cfg_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_UNPROG;
        else        state_q <= state_d;
    end

    // transitions: program, arm, disarm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_UNPROG: if (cfg_take) state_d = en_next ? WS_LIVE : WS_PARKED;
            WS_PARKED: if (en_next)  state_d = WS_LIVE;
            WS_LIVE:   if (!en_next) state_d = WS_PARKED;
            default:   state_d = WS_UNPROG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
        end else if (cfg_take) begin
            base_q <= wr_base;
            mask_q <= cfg_mask;
        end
    end

    // match
    always_comb begin
        addr_in    = acc_addr & SPACE_KEEP;
        programmed = (state_q != WS_UNPROG);
        hit_d      = acc_valid && acc_sel && programmed
                  && ((addr_in & ~mask_q) == base_q)
                  && (acc_local || (state_q == WS_LIVE));
        off_d      = hit_d ? (addr_in & mask_q) : '0;
        lmon_d     = hit_d && ((off_d | AW'(3)) == mask_q);
        bus_d      = hit_d && !acc_local;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_o  <= 1'b0;
            lmon_o <= 1'b0;
            bus_o  <= 1'b0;
            off_o  <= '0;
        end else begin
            hit_o  <= hit_d;
            lmon_o <= lmon_d;
            bus_o  <= bus_d;
            off_o  <= off_d;
        end
    end

    assign ready_o = programmed;

    assert_unprog_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_UNPROG) |=> !hit_o);
    assert_bus_needs_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WS_LIVE) |=> !bus_o);
    assert_lmon_only_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lmon_o |-> hit_o);
    assert_reject_keeps_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |=> ($stable(base_q) && $stable(mask_q)));
endmodule

// File: rtl/swd_decoder.sv
module swd_decoder
    import swd_pkg::*;
#(
    parameter int unsigned AW         = SWD_AW,
    parameter int unsigned CODE_W     = SWD_CODE_W,
    parameter int unsigned N_MIN_EXP  = 19,
    parameter int unsigned N_MAX_CODE = 3,
    parameter int unsigned N_SPACE    = 24,
    parameter int unsigned W_MIN_EXP  = 12,
    parameter int unsigned W_MAX_CODE = 15,
    parameter int unsigned W_ALIGN    = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [AW-1:0]     cfg_base,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              acc_valid,
    input  logic              acc_wide,
    input  logic              acc_local,
    input  logic [AW-1:0]     acc_addr,
    output logic              dec_hit,
    output logic              dec_wide,
    output logic [AW-1:0]     dec_offset,
    output logic              dec_lmon,
    output logic              dec_bus,
    output logic [1:0]        stat_ready,
    output logic              stat_enable,
    output logic              stat_cfg_err
);
    localparam int unsigned NWIN = 2;

    logic            en_q, en_d, err_q, ctl_wr;
    logic [NWIN-1:0] w_hit, w_lmon, w_bus, w_rdy, w_rej;
    logic [AW-1:0]   w_off [NWIN];

    assign ctl_wr = cfg_we && (cfg_sel == CFG_SEL_CTRL);
    assign en_d   = ctl_wr ? cfg_base[0] : en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            en_q <= en_d;
            if (|w_rej)                      err_q <= 1'b1;
            else if (ctl_wr && cfg_base[1])  err_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        localparam int unsigned MIN_EXP  = (g == 0) ? N_MIN_EXP  : W_MIN_EXP;
        localparam int unsigned MAX_CODE = (g == 0) ? N_MAX_CODE : W_MAX_CODE;
        localparam int unsigned ALIGN_F  = (g == 0) ? N_MIN_EXP  : W_ALIGN;
        localparam int unsigned SPACE_B  = (g == 0) ? N_SPACE    : AW;

        swd_window #(
            .AW(AW), .CODE_W(CODE_W), .MIN_EXP(MIN_EXP), .MAX_CODE(MAX_CODE),
            .ALIGN_FLOOR(ALIGN_F), .SPACE_BITS(SPACE_B)
        ) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_sel == 2'(g))),
            .wr_base   (cfg_base),
            .wr_code   (cfg_code),
            .en_next   (en_d),
            .acc_valid (acc_valid),
            .acc_sel   (acc_wide == 1'(g)),
            .acc_local (acc_local),
            .acc_addr  (acc_addr),
            .hit_o     (w_hit[g]),
            .lmon_o    (w_lmon[g]),
            .bus_o     (w_bus[g]),
            .ready_o   (w_rdy[g]),
            .reject_o  (w_rej[g]),
            .off_o     (w_off[g])
        );
    end

    assign dec_hit      = |w_hit;
    assign dec_wide     = w_hit[1];
    assign dec_offset   = w_off[0] | w_off[1];
    assign dec_lmon     = |w_lmon;
    assign dec_bus      = |w_bus;
    assign stat_ready   = w_rdy;
    assign stat_enable  = en_q;
    assign stat_cfg_err = err_q;

    assert_single_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(w_hit));
    assert_local_stays_off_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_local) |=> !dec_bus);
    assert_reject_raises_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|w_rej) |=> stat_cfg_err);
    assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ready[0] |=> stat_ready[0]) and (stat_ready[1] |=> stat_ready[1]));
endmodule

// File: tb/swd_decoder_tb.sv
module swd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_base = '0;
    logic [3:0]  cfg_code = '0;
    logic        acc_valid = 1'b0, acc_wide = 1'b0, acc_local = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        dec_hit, dec_wide, dec_lmon, dec_bus, stat_enable, stat_cfg_err;
    logic [31:0] dec_offset;
    logic [1:0]  stat_ready;

    int checks = 0, failures = 0, cycles = 0;
    bit finished = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    swd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_base(cfg_base), .cfg_code(cfg_code), .acc_valid(acc_valid),
        .acc_wide(acc_wide), .acc_local(acc_local), .acc_addr(acc_addr),
        .dec_hit(dec_hit), .dec_wide(dec_wide), .dec_offset(dec_offset),
        .dec_lmon(dec_lmon), .dec_bus(dec_bus), .stat_ready(stat_ready),
        .stat_enable(stat_enable), .stat_cfg_err(stat_cfg_err)
    );

    // reference model
    bit     m_prog [2];
    longint m_base [2];
    int     m_exp  [2];
    bit     m_en, m_err;
    bit     e_hit, e_wide, e_lmon, e_bus, e_en, e_err;
    longint e_off;
    bit [1:0] e_ready;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prog = '{0, 0}; m_base = '{0, 0}; m_exp = '{0, 0};
            m_en = 0; m_err = 0;
            e_hit = 0; e_wide = 0; e_lmon = 0; e_bus = 0; e_off = 0;
            e_ready = 0; e_en = 0; e_err = 0;
        end else begin
            e_hit = 0; e_wide = 0; e_lmon = 0; e_bus = 0; e_off = 0;
            if (acc_valid) begin
                int w;
                longint a, sz;
                w = acc_wide ? 1 : 0;
                a = acc_wide ? longint'(acc_addr) : longint'(acc_addr[23:0]);
                if (m_prog[w] && ((a >> m_exp[w]) == (m_base[w] >> m_exp[w]))
                    && (acc_local || m_en)) begin
                    sz = 64'd1 << m_exp[w];
                    e_hit = 1; e_wide = (w == 1);
                    e_off = a & (sz - 1);
                    e_lmon = (e_off >= sz - 4);
                    e_bus = !acc_local;
                end
            end
            if (cfg_we) begin
                longint b;
                int ex;
                bit ok;
                b = longint'(cfg_base);
                if (cfg_sel == 2'd0) begin
                    ex = 19 + int'(cfg_code);
                    ok = (cfg_code <= 3) && (b < 64'h100_0000) && ((b % (64'd1 << ex)) == 0);
                    if (ok) begin m_prog[0] = 1; m_base[0] = b; m_exp[0] = ex; end
                    else m_err = 1;
                end else if (cfg_sel == 2'd1) begin
                    ex = 12 + int'(cfg_code);
                    ok = ((b % (64'd1 << 27)) == 0);
                    if (ok) begin m_prog[1] = 1; m_base[1] = b; m_exp[1] = ex; end
                    else m_err = 1;
                end else if (cfg_sel == 2'd2) begin
                    m_en = cfg_base[0];
                    if (cfg_base[1]) m_err = 0;
                end
            end
            e_ready = {m_prog[1], m_prog[0]};
            e_en = m_en; e_err = m_err;
        end
    end

    // cycle compare
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (dec_hit !== e_hit || dec_wide !== e_wide || dec_lmon !== e_lmon ||
                dec_bus !== e_bus || longint'(dec_offset) !== e_off ||
                stat_ready !== e_ready || stat_enable !== e_en || stat_cfg_err !== e_err) begin
                failures++;
                $display("FAIL %s model: act hit=%0b wide=%0b off=%h lmon=%0b bus=%0b rdy=%b en=%0b err=%0b exp hit=%0b wide=%0b off=%h lmon=%0b bus=%0b rdy=%b en=%0b err=%0b",
                    cur_tag, dec_hit, dec_wide, dec_offset, dec_lmon, dec_bus, stat_ready, stat_enable, stat_cfg_err,
                    e_hit, e_wide, e_off, e_lmon, e_bus, e_ready, e_en, e_err);
            end
        end
    end

    task automatic chk(string tag, longint act, longint exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp_v);
        end
    endtask

    task automatic cfg(logic [1:0] sel, logic [31:0] base, logic [3:0] code, string tag);
        @(negedge clk);
        cur_tag = tag;
        cfg_we = 1; cfg_sel = sel; cfg_base = base; cfg_code = code;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // hand-computed probe: packs {hit,wide,lmon,bus,offset}
    task automatic probe(logic [31:0] addr, bit wide, bit loc, bit h, logic [31:0] off, bit lm, string tag);
        @(negedge clk);
        cur_tag = tag;
        acc_valid = 1; acc_addr = addr; acc_wide = wide; acc_local = loc;
        @(negedge clk);
        chk(tag, {dec_hit, dec_wide, dec_lmon, dec_bus, dec_offset},
                 {h, h & wide, lm, h & ~loc, off});
        acc_valid = 0;
    endtask

    task automatic stat(logic [1:0] rdy, bit en, bit err, string tag);
        chk(tag, {stat_ready, stat_enable, stat_cfg_err}, {rdy, en, err});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        stat(2'b00, 0, 0, "R1 reset status");
        chk("R1 reset hit", dec_hit, 0);
        rst_n = 1;
        probe(32'h0000_0000, 0, 0, 0, 0, 0, "R1 unprogrammed narrow");
        probe(32'h0000_0000, 1, 1, 0, 0, 0, "R1 unprogrammed wide local");
        cfg(2'd2, 32'h1, 0, "R2 enable");
        probe(32'h0000_0000, 0, 0, 0, 0, 0, "R1 enabled but unprogrammed");
        cfg(2'd0, 32'h0020_0000, 4'd1, "R3 program 1MB");
        stat(2'b01, 1, 0, "R10 ready narrow");
        probe(32'h002A_BCDE, 0, 0, 1, 32'h000A_BCDE, 0, "R6 inside");
        probe(32'hFF2A_BCDE, 0, 0, 1, 32'h000A_BCDE, 0, "R6 upper bits ignored");
        probe(32'h0030_0000, 0, 0, 0, 0, 0, "R6 just above");
        probe(32'h001F_FFFC, 0, 0, 0, 0, 0, "R6 just below");
        probe(32'h002F_FFFC, 0, 0, 1, 32'h000F_FFFC, 1, "R7 last word");
        probe(32'h002F_FFFB, 0, 0, 1, 32'h000F_FFFB, 0, "R7 before last word");
        probe(32'h002A_BCDE, 1, 0, 0, 0, 0, "R12 wrong space");
        cfg(2'd0, 32'h0028_0000, 4'd1, "R4 misaligned base");
        stat(2'b01, 1, 1, "R9 error set");
        probe(32'h002A_BCDE, 0, 0, 1, 32'h000A_BCDE, 0, "R9 window unchanged");
        cfg(2'd0, 32'h0000_0000, 4'd4, "R3 bad code");
        probe(32'h0000_0010, 0, 0, 0, 0, 0, "R3 bad code ignored");
        cfg(2'd0, 32'h0100_0000, 4'd0, "R4 outside space");
        probe(32'h0000_0010, 0, 0, 0, 0, 0, "R4 outside base ignored");
        cfg(2'd2, 32'h3, 0, "R9 clear error");
        stat(2'b01, 1, 0, "R9 error cleared");
        cfg(2'd0, 32'h00C0_0000, 4'd3, "R3 program 4MB");
        probe(32'h00FF_FFFC, 0, 0, 1, 32'h003F_FFFC, 1, "R3 4MB top word");
        probe(32'h00BF_FFFC, 0, 0, 0, 0, 0, "R3 4MB below");
        cfg(2'd0, 32'h0008_0000, 4'd0, "R3 program 512KB");
        probe(32'h000F_FFFF, 0, 0, 1, 32'h0007_FFFF, 1, "R3 512KB top byte");
        probe(32'h0010_0000, 0, 0, 0, 0, 0, "R3 512KB above");
        probe(32'h1800_0000, 1, 0, 0, 0, 0, "R1 wide unprogrammed");
        cfg(2'd1, 32'h1800_0000, 4'd0, "R5 program 4KB");
        stat(2'b11, 1, 0, "R10 ready both");
        probe(32'h1800_0FFC, 1, 0, 1, 32'h0000_0FFC, 1, "R5 4KB top word");
        probe(32'h1800_1000, 1, 0, 0, 0, 0, "R5 4KB above");
        cfg(2'd1, 32'h1800_1000, 4'd0, "R5 misaligned wide base");
        stat(2'b11, 1, 1, "R9 wide reject");
        probe(32'h1800_0004, 1, 0, 1, 32'h0000_0004, 0, "R9 wide unchanged");
        cfg(2'd1, 32'h0800_0000, 4'd15, "R5 program 128MB");
        probe(32'h0FFF_FFFC, 1, 0, 1, 32'h07FF_FFFC, 1, "R5 128MB top word");
        probe(32'h1000_0000, 1, 0, 0, 0, 0, "R5 128MB above");
        probe(32'h0FFF_FFFC, 0, 0, 0, 0, 0, "R12 narrow space miss");
        cfg(2'd2, 32'h0, 0, "R2 disable");
        probe(32'h0FFF_FFFC, 1, 0, 0, 0, 0, "R2 disabled bus miss");
        probe(32'h0FFF_FFFC, 1, 1, 1, 32'h07FF_FFFC, 1, "R8 local wide");
        probe(32'h0008_0010, 0, 1, 1, 32'h0000_0010, 0, "R8 local narrow");
        cfg(2'd3, 32'hFFFF_FFFF, 4'hF, "R9 unused select");
        stat(2'b11, 0, 1, "R9 unused select no effect");
        cfg(2'd2, 32'h3, 0, "R2 re-enable");
        probe(32'h0008_0010, 0, 0, 1, 32'h0000_0010, 0, "R2 bus hit");
        // R11: access in the same cycle as a reprogramming write
        @(negedge clk);
        cur_tag = "R11";
        cfg_we = 1; cfg_sel = 2'd0; cfg_base = 32'h0; cfg_code = 4'd0;
        acc_valid = 1; acc_wide = 0; acc_local = 0; acc_addr = 32'h0008_0004;
        @(negedge clk);
        cfg_we = 0;
        chk("R11 old window used", {dec_hit, dec_offset}, {1'b1, 32'h4});
        @(negedge clk);
        chk("R11 new window used", dec_hit, 0);
        acc_valid = 0;
        // random phase against the model
        cur_tag = "R6 random";
        for (int i = 0; i < 600; i++) begin
            logic [31:0] pick;
            @(negedge clk);
            case ($urandom_range(0, 4))
                0: pick = 32'h0020_0000;
                1: pick = 32'h00C0_0000;
                2: pick = 32'h0800_0000;
                3: pick = 32'h1800_0000;
                default: pick = 32'h0000_0000;
            endcase
            cfg_we = ($urandom_range(0, 7) == 0);
            cfg_sel = 2'($urandom_range(0, 3));
            cfg_base = ($urandom_range(0, 3) == 0) ? (pick | 32'h0008_0000) :
                       (cfg_sel == 2'd2 ? 32'($urandom_range(0, 3)) : pick);
            cfg_code = 4'($urandom_range(0, 15));
            acc_valid = ($urandom_range(0, 3) != 0);
            acc_wide = 1'($urandom_range(0, 1));
            acc_local = ($urandom_range(0, 3) == 0);
            acc_addr = ($urandom_range(0, 1) == 0) ? (pick + 32'($urandom_range(0, 32'h3F_FFFF)))
                                                   : (pick - 32'($urandom_range(1, 8)));
        end
        @(negedge clk);
        cfg_we = 0; acc_valid = 0;
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog: act=%0d cycles exp=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule